// File: doc/BRIEF.md
# Opcode-Driven Execute-Cycle Sequencer

This block carries out the execute phase of a small accumulator-style processor. A host first places an instruction word in the instruction register, sets the program counter so that it already points at the following instruction, and optionally presets the general register R1 and words of the internal memory. A one-cycle start pulse then launches a timed micro-step sequence chosen by the opcode in the top four bits of the instruction. The low twelve bits are a direct word address into a 4096-word internal memory.

Two instructions exist. The add instruction copies the address into the address register, reads the addressed word into the buffer register, then adds the buffer to R1. The increment-and-skip instruction performs the same first two steps, then increments the buffer in place, and in a fourth step writes the buffer back to memory while, in that very step, advancing the program counter by one when the buffer holds zero. Any other opcode finishes at once without touching state. The end of every instruction is marked by a single-cycle done pulse.

While no instruction runs, the host can load the registers and read or write the memory through a simple host port; while one runs, those inputs and further start pulses have no effect.

Top module: `exec_seq`

## Requirements
- R1: After synchronous reset, busy and done are 0, pc is 0 and r1 is 0.
- R2: While busy is 0, ir_we, pc_we and r1_we load their registers on the clock edge, host_we writes host_wdata at host_addr, and host_rdata shows the word at host_addr one cycle after the address is presented.
- R3: For an instruction word with bits [15:12] = 4'h1 (add), r1 becomes r1 plus the memory word at address bits [11:0], modulo 2^16; memory and pc are unchanged, and done is high on the 4th rising edge counted from the edge that samples start.
- R4: r1 changes during execution only by the add instruction; increment-and-skip and unknown opcodes leave r1 unchanged.
- R5: For bits [15:12] = 4'h2 (increment-and-skip), the memory word at bits [11:0] becomes its old value plus 1 modulo 2^16, and done is high on the 5th rising edge counted from the edge that samples start.
- R6: For increment-and-skip, pc becomes its loaded value plus 1 exactly when the incremented word is zero (old value 16'hFFFF); otherwise pc is unchanged. Add never changes pc.
- R7: An instruction whose opcode is neither 4'h1 nor 4'h2 raises done on the 1st rising edge after start is sampled and changes no register and no memory word.
- R8: While busy is 1, start, ir_we, pc_we, r1_we and host_we are ignored: the running instruction completes with its normal latency and result, and no host write lands.
- R9: done stays high for exactly one cycle per instruction and is never high together with busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin executing the instruction register contents |
| ir_we | input | 1 | Load instruction register (idle only) |
| ir_wdata | input | 16 | Instruction word: opcode [15:12], address [11:0] |
| pc_we | input | 1 | Load program counter (idle only) |
| pc_wdata | input | 12 | Program counter load value |
| r1_we | input | 1 | Load R1 (idle only) |
| r1_wdata | input | 16 | R1 load value |
| host_we | input | 1 | Host memory write enable (idle only) |
| host_addr | input | 12 | Host memory address |
| host_wdata | input | 16 | Host memory write data |
| host_rdata | output | 16 | Memory read data, one cycle after host_addr |
| busy | output | 1 | An instruction is in its micro-step sequence |
| done | output | 1 | One-cycle pulse at the end of an instruction |
| pc | output | 12 | Program counter |
| r1 | output | 16 | General register R1 |

## Verification
The bench builds the block with its default address width of 12 bits, so the word width is 16 and random addresses span the whole 4096-word memory, including address 0 and the top word. With 16-bit words the wrap of 16'hFFFF to zero, the only value that triggers a skip, is reached directly by preloading memory, and R1 overflow on add is reached by random operands. Stray start pulses and host writes injected in mid-sequence exercise the ignore rule against a scratch word read back afterwards.

// File: rtl/exec_seq_pkg.sv
package exec_seq_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_ADD = 4'h1;
  localparam logic [OPC_W-1:0] OPC_ISZ = 4'h2;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_T4   = 3'd4
  } step_t;
endpackage

// File: rtl/exec_mem.sv
module exec_mem #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store[addr] <= wdata;
    end
    rdata <= store[addr];
  end
endmodule

// File: rtl/exec_alu.sv
module exec_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         inc,
  output logic [W-1:0] y
);
  localparam logic [W-1:0] ONE = 1;

  logic [W-1:0] operand;

  always_comb begin
    operand = inc ? ONE : b;
    y       = a + operand;
  end
endmodule

// File: rtl/exec_ctrl.sv
module exec_ctrl
  import exec_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [OPC_W-1:0] opcode,
  output step_t            step,
  output logic             done,
  output logic             is_isz
);
  logic known;

  always_comb begin
    is_isz = (opcode == OPC_ISZ);
    known  = (opcode == OPC_ADD) || is_isz;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= ST_IDLE;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (step)
        ST_IDLE: begin
          if (start) begin
            if (known) begin
              step <= ST_T1;
            end else begin
              done <= 1'b1;
            end
          end
        end
        ST_T1: step <= ST_T2;
        ST_T2: step <= ST_T3;
        ST_T3: begin
          if (is_isz) begin
            step <= ST_T4;
          end else begin
            step <= ST_IDLE;
            done <= 1'b1;
          end
        end
        ST_T4: begin
          step <= ST_IDLE;
          done <= 1'b1;
        end
        default: step <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/exec_seq.sv
module exec_seq
  import exec_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int DATA_W = OPC_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ir_we,
  input  logic [DATA_W-1:0] ir_wdata,
  input  logic              pc_we,
  input  logic [ADDR_W-1:0] pc_wdata,
  input  logic              r1_we,
  input  logic [DATA_W-1:0] r1_wdata,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] r1
);
  localparam logic [ADDR_W-1:0] PC_ONE = 1;
  localparam logic [DATA_W-1:0] ZERO_W = '0;

  step_t             step;
  logic              is_isz;
  logic [DATA_W-1:0] ir;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mbr;
  logic [ADDR_W-1:0] ir_addr;
  logic [OPC_W-1:0]  ir_opc;

  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata;

  logic [DATA_W-1:0] alu_a;
  logic [DATA_W-1:0] alu_y;

  assign ir_addr = ir[ADDR_W-1:0];
  assign ir_opc  = ir[DATA_W-1:ADDR_W];
  assign busy    = (step != ST_IDLE);

  exec_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .opcode (ir_opc),
    .step   (step),
    .done   (done),
    .is_isz (is_isz)
  );

  // Memory port: host owns it when idle, the sequencer while busy.
  always_comb begin
    if (busy) begin
      mem_we    = (step == ST_T4);
      mem_addr  = (step == ST_T1) ? ir_addr : mar;
      mem_wdata = mbr;
    end else begin
      mem_we    = host_we;
      mem_addr  = host_addr;
      mem_wdata = host_wdata;
    end
  end

  exec_mem #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  assign host_rdata = mem_rdata;
  assign alu_a      = is_isz ? mbr : r1;

  exec_alu #(
    .W (DATA_W)
  ) u_alu (
    .a   (alu_a),
    .b   (mbr),
    .inc (is_isz),
    .y   (alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ir  <= '0;
      pc  <= '0;
      r1  <= '0;
      mar <= '0;
      mbr <= '0;
    end else begin
      if (!busy) begin
        if (ir_we) ir <= ir_wdata;
        if (pc_we) pc <= pc_wdata;
        if (r1_we) r1 <= r1_wdata;
      end
      case (step)
        ST_T1: mar <= ir_addr;
        ST_T2: mbr <= mem_rdata;
        ST_T3: begin
          if (is_isz) mbr <= alu_y;
          else        r1  <= alu_y;
        end
        ST_T4: begin
          if (mbr == ZERO_W) pc <= pc + PC_ONE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/exec_seq_chk.sv
module exec_seq_chk
  import exec_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int DATA_W = OPC_W + ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] pc,
  input logic [DATA_W-1:0] r1,
  input logic [DATA_W-1:0] ir,
  input logic              mem_we
);
  localparam logic [ADDR_W-1:0] PC_ONE = 1;

  logic [2:0]       run_len;
  logic [OPC_W-1:0] opc;

  assign opc = ir[DATA_W-1:ADDR_W];

  always_ff @(posedge clk) begin
    if (rst) run_len <= '0;
    else     run_len <= busy ? run_len + 3'd1 : 3'd0;
  end

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done || $past(start))); // R9

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_len < 3'd4)); // R8

  AST_BAD_OPC_QUICK: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && opc != OPC_ADD && opc != OPC_ISZ) |=> (done && !busy)); // R7

  AST_R1_ONLY_ADD: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && !$stable(r1)) |-> ($past(opc) == OPC_ADD)); // R4

  AST_PC_SKIP_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && !$stable(pc)) |-> (pc == $past(pc) + PC_ONE)); // R6

  AST_WRITE_ONLY_ISZ: assert property (@(posedge clk) disable iff (rst)
    (busy && mem_we) |-> (opc == OPC_ISZ)); // R5
endmodule

bind exec_seq exec_seq_chk #(
  .ADDR_W (ADDR_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .pc     (pc),
  .r1     (r1),
  .ir     (ir),
  .mem_we (mem_we)
);

// File: tb/tb_exec_seq.sv
module tb_exec_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam logic [AW-1:0] SCRATCH = 12'h800;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          ir_we = 1'b0;
  logic [DW-1:0] ir_wdata = '0;
  logic          pc_we = 1'b0;
  logic [AW-1:0] pc_wdata = '0;
  logic          r1_we = 1'b0;
  logic [DW-1:0] r1_wdata = '0;
  logic          host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic          busy;
  logic          done;
  logic [AW-1:0] pc;
  logic [DW-1:0] r1;

  int total = 0;
  int bad = 0;

  logic [DW-1:0] model_mem [1 << AW];
  logic [DW-1:0] exp_r1;
  logic [AW-1:0] exp_pc;
  logic [AW-1:0] pool [8];

  always #(CLK_PERIOD / 2) clk = ~clk;

  exec_seq #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .start(start),
    .ir_we(ir_we), .ir_wdata(ir_wdata),
    .pc_we(pc_we), .pc_wdata(pc_wdata),
    .r1_we(r1_we), .r1_wdata(r1_wdata),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .busy(busy), .done(done), .pc(pc), .r1(r1)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_latency(input logic [3:0] opc);
    if (opc == 4'h1) return 4;
    if (opc == 4'h2) return 5;
    return 1;
  endfunction

  task automatic mem_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
    model_mem[a] = d;
  endtask

  task automatic mem_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    host_addr = a;
    @(posedge clk);
    #1 d = host_rdata;
  endtask

  task automatic load_regs(input logic [DW-1:0] irv, input logic [AW-1:0] pcv,
                           input logic [DW-1:0] r1v);
    @(negedge clk);
    ir_we = 1'b1; ir_wdata = irv;
    pc_we = 1'b1; pc_wdata = pcv;
    r1_we = 1'b1; r1_wdata = r1v;
    @(negedge clk);
    ir_we = 1'b0; pc_we = 1'b0; r1_we = 1'b0;
    exp_r1 = r1v;
    exp_pc = pcv;
  endtask

  // Run one instruction; optionally inject stray inputs mid-sequence.
  task automatic run_instr(input logic [DW-1:0] irv, input bit stray);
    int n;
    logic [AW-1:0] a;
    logic [3:0] opc;
    logic [DW-1:0] got;
    opc = irv[15:12];
    a = irv[11:0];
    @(negedge clk);
    start = 1'b1;
    n = 0;
    do begin
      @(posedge clk);
      #1;
      n++;
      if (n == 1) start = 1'b0;
      if (stray && n == 2) begin
        start = 1'b1; host_we = 1'b1; host_addr = SCRATCH; host_wdata = 16'hDEAD;
        ir_we = 1'b1; ir_wdata = 16'h0000; r1_we = 1'b1; r1_wdata = 16'h5555;
        pc_we = 1'b1; pc_wdata = 12'h0AA;
      end
      if (stray && n == 3) begin
        start = 1'b0; host_we = 1'b0; ir_we = 1'b0; r1_we = 1'b0; pc_we = 1'b0;
      end
    end while (!done && n < 20);
    if (opc == 4'h1) begin
      exp_r1 = exp_r1 + model_mem[a];
    end else if (opc == 4'h2) begin
      model_mem[a] = model_mem[a] + 16'd1;
      if (model_mem[a] == 16'h0000) exp_pc = exp_pc + 12'd1;
    end
    if (opc == 4'h1)      chk("R3 latency", n, exp_latency(opc));
    else if (opc == 4'h2) chk("R5 latency", n, exp_latency(opc));
    else                  chk("R7 latency", n, exp_latency(opc));
    chk(stray ? "R8 busy at done" : "R9 busy at done", busy, 0);
    chk(opc == 4'h1 ? "R3 r1" : "R4 r1", r1, exp_r1);
    chk(opc == 4'h2 ? "R6 pc" : "R7 pc", pc, exp_pc);
    @(posedge clk);
    #1 chk("R9 done one cycle", done, 0);
    mem_read(a, got);
    chk(opc == 4'h2 ? "R5 mem" : "R3 mem", got, model_mem[a]);
    if (stray) begin
      mem_read(SCRATCH, got);
      chk("R8 stray write ignored", got, model_mem[SCRATCH]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] got;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 pc", pc, 0);
    chk("R1 r1", r1, 0);

    // Host port readback
    mem_write(SCRATCH, 16'h1357);
    mem_read(SCRATCH, got);
    chk("R2 host readback", got, 16'h1357);
    load_regs(16'h0000, 12'h123, 16'h4242);
    chk("R2 pc load", pc, 12'h123);
    chk("R2 r1 load", r1, 16'h4242);

    // Directed: add with overflow
    mem_write(12'h000, 16'hF000);
    load_regs({4'h1, 12'h000}, 12'h010, 16'h2001);
    run_instr({4'h1, 12'h000}, 1'b0);
    // Directed: increment-and-skip, wrap at top address
    mem_write(12'hFFF, 16'hFFFF);
    load_regs({4'h2, 12'hFFF}, 12'hFFF, 16'h0003);
    run_instr({4'h2, 12'hFFF}, 1'b0);
    // Directed: increment without skip
    mem_write(12'h044, 16'hFFFE);
    load_regs({4'h2, 12'h044}, 12'h020, 16'h0003);
    run_instr({4'h2, 12'h044}, 1'b0);
    // Directed: unknown opcodes
    load_regs({4'h0, 12'h044}, 12'h030, 16'h7777);
    run_instr({4'h0, 12'h044}, 1'b0);
    load_regs({4'hF, 12'hFFF}, 12'h031, 16'h7777);
    run_instr({4'hF, 12'hFFF}, 1'b0);
    // Directed: strays during add and during increment-and-skip
    mem_write(12'h100, 16'h0011);
    load_regs({4'h1, 12'h100}, 12'h040, 16'h0100);
    run_instr({4'h1, 12'h100}, 1'b1);
    mem_write(12'h101, 16'hFFFF);
    load_regs({4'h2, 12'h101}, 12'h041, 16'h0100);
    run_instr({4'h2, 12'h101}, 1'b1);

    // Random mix over a small address pool to force reuse and wraps
    pool[0] = 12'h000;
    pool[1] = 12'hFFF;
    for (int i = 2; i < 8; i++) begin
      logic [AW-1:0] ra;
      do ra = AW'($urandom); while (ra == SCRATCH);
      pool[i] = ra;
    end
    for (int i = 0; i < 8; i++) begin
      logic [DW-1:0] v;
      v = ($urandom % 3 == 0) ? 16'hFFFF - DW'($urandom % 2) : DW'($urandom);
      mem_write(pool[i], v);
    end
    for (int k = 0; k < 60; k++) begin
      logic [3:0] opc;
      logic [AW-1:0] a;
      int sel;
      sel = $urandom % 8;
      opc = (sel < 3) ? 4'h1 : (sel < 6) ? 4'h2 : 4'($urandom);
      a = pool[$urandom % 8];
      if (k % 10 == 0 && opc == 4'h2 && model_mem[a] != 16'hFFFF)
        mem_write(a, 16'hFFFF);
      load_regs({opc, a}, AW'($urandom), DW'($urandom));
      run_instr({opc, a}, (k % 7) == 3);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule